// File: doc/BRIEF.md
# Byte-Lane Static Memory Emulator

This block stands in for an asynchronous 16-bit static memory behind two chip selects, one active low and one active high. It also has an active-low output enable, an active-low write strobe and one active-low enable per byte lane. An internal sampling clock captures the control pins on every rising edge. Each sample is sorted into one of four conditions: deselected, output disabled, read or write. Read data comes out on a data bus with a per-lane drive-enable vector, so the surrounding logic can model a tri-state pad. Writes are masked by byte lane.

A write stays open for as long as the write condition holds. It is committed to storage only when that condition ends. The address, data and lane mask are the ones sampled in the last write cycle, so the write takes effect at the earliest point the strobes stop overlapping. A retention flag is raised while the chip is deselected. Storage contents are never cleared by reset.

The address port is `ADDR_W` bits wide (18 by default, for 256K words). The array that is actually built holds `2**STORE_W` words and is indexed by the low `STORE_W` address bits.

Top module: `lane_sram_emu`

## Requirements
- R1: While `rst` is high, `rdata`, `rdata_oe` and `hold_mode` read zero at the next sample, and a write that is still open is dropped without touching storage.
- R2: When `sel_lo_n`=1, or `sel_hi`=0, or both bits of `lane_n` are 1, the chip is deselected. One cycle later `rdata_oe` is 0, `rdata` is 0 and `hold_mode` is 1, whatever the other pins are.
- R3: When the chip is selected with `rd_en_n`=1 and `wr_en_n`=1, one cycle later `rdata_oe` is 0, `rdata` is 0 and `hold_mode` is 0.
- R4: When the chip is selected with `rd_en_n`=0 and `wr_en_n`=1, one cycle later `rdata_oe[i]` equals the inverse of `lane_n[i]`. Lane 0 is bits 7:0 and lane 1 is bits 15:8. Each driven lane carries the stored byte, and each undriven lane reads 0.
- R5: When the chip is selected with `wr_en_n`=0, it is in write mode whatever `rd_en_n` is. One cycle later `rdata_oe` is 0.
- R6: A committed write changes only the lanes whose `lane_n` bit was 0 in the final write cycle. It uses the `addr` and `wdata` of that final cycle. The other lanes keep their contents.
- R7: Storage changes on the first sampled cycle whose condition is not write. It does not matter which pin ended the write: `wr_en_n` rising, `sel_lo_n` rising, `sel_hi` falling, or both lanes going disabled.
- R8: A read sampled in the same cycle a write commits returns the newly written bytes.
- R9: The storage index is `addr[STORE_W-1:0]`. Addresses that differ only above that field refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_lo_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| rd_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write strobe |
| lane_n | input | LANES (2) | Active-low byte-lane enables, bit 0 for bits 7:0 |
| addr | input | ADDR_W (18) | Word address |
| wdata | input | LANES*LANE_W (16) | Write data |
| rdata | output | LANES*LANE_W (16) | Read data, zero on undriven lanes |
| rdata_oe | output | LANES (2) | Per-lane drive enable |
| hold_mode | output | 1 | Retention flag, high while deselected |

## Verification
Suppose the pending-write register holds the wrong state. A lost, doubled or early commit stays hidden until the next read of that word. It then shows as a wrong byte on `rdata`, one cycle after the read is sampled. The bench therefore reads each location immediately after every write ends, including in the commit cycle itself. A decode fault shows at once, within one cycle, as a wrong `rdata_oe` lane or `hold_mode` level. That is why those outputs are compared on every clock.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

    typedef enum logic [1:0] {
        MD_DESEL  = 2'd0,
        MD_OUTOFF = 2'd1,
        MD_READ   = 2'd2,
        MD_WRITE  = 2'd3
    } mode_e;

    // Deselection dominates; a write dominates the output enable.
    function automatic mode_e classify(input logic sel_lo_n, input logic sel_hi,
                                       input logic rd_en_n, input logic wr_en_n,
                                       input logic no_lane);
        mode_e m;
        if (sel_lo_n || !sel_hi || no_lane) m = MD_DESEL;
        else if (!wr_en_n)                  m = MD_WRITE;
        else if (!rd_en_n)                  m = MD_READ;
        else                                m = MD_OUTOFF;
        return m;
    endfunction

endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
    import lane_sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_lo_n,
    input  logic             sel_hi,
    input  logic             rd_en_n,
    input  logic             wr_en_n,
    input  logic [LANES-1:0] lane_n,
    output mode_e            mode,
    output logic [LANES-1:0] lane_on
);
    always_comb begin
        lane_on = ~lane_n;
        mode    = classify(sel_lo_n, sel_hi, rd_en_n, wr_en_n, &lane_n);
    end
endmodule

// File: rtl/lane_sram_wrcap.sv
module lane_sram_wrcap
    import lane_sram_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] lane_on,
    output logic             commit,
    output logic [IDX_W-1:0] c_idx,
    output logic [DW-1:0]    c_data,
    output logic [LANES-1:0] c_mask
);
    typedef struct packed {
        logic             open;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
        logic [LANES-1:0] mask;
    } pend_t;

    pend_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (mode == MD_WRITE) begin
            pend_q <= '{open: 1'b1, idx: idx, data: wdata, mask: lane_on};
        end else begin
            pend_q.open <= 1'b0;
        end
    end

    assign commit = pend_q.open && (mode != MD_WRITE) && !rst;
    assign c_idx  = pend_q.idx;
    assign c_data = pend_q.data;
    assign c_mask = pend_q.mask;
endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array #(
    parameter int IDX_W  = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DEPTH = 1 << IDX_W,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IDX_W-1:0] c_idx,
    input  logic [DW-1:0]    c_data,
    input  logic [LANES-1:0] c_mask,
    input  logic             rd_go,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [LANES-1:0] rd_mask,
    output logic [DW-1:0]    rdata,
    output logic [LANES-1:0] rdata_oe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] out_q;
        logic              oe_q;
        logic              wr_here;

        assign wr_here = commit && c_mask[g];

        always_ff @(posedge clk) begin
            if (wr_here) mem[c_idx] <= c_data[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
                oe_q  <= 1'b0;
            end else if (rd_go && rd_mask[g]) begin
                oe_q  <= 1'b1;
                out_q <= (wr_here && c_idx == rd_idx) ? c_data[g*LANE_W +: LANE_W]
                                                      : mem[rd_idx];
            end else begin
                oe_q  <= 1'b0;
                out_q <= '0;
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = out_q;
        assign rdata_oe[g]               = oe_q;
    end
endmodule

// File: rtl/lane_sram_emu.sv
module lane_sram_emu
    import lane_sram_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int STORE_W = 10,
    parameter int LANES   = 2,
    parameter int LANE_W  = 8,
    localparam int DW     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [LANES-1:0]  rdata_oe,
    output logic              hold_mode
);
    mode_e              mode;
    logic [LANES-1:0]   lane_on;
    logic [STORE_W-1:0] idx;
    logic               commit;
    logic [STORE_W-1:0] c_idx;
    logic [DW-1:0]      c_data;
    logic [LANES-1:0]   c_mask;
    logic               hold_q;

    assign idx = addr[STORE_W-1:0];

    if (STORE_W < ADDR_W) begin : g_alias
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:STORE_W];
    end

    lane_sram_decode #(.LANES(LANES)) u_dec (
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .rd_en_n  (rd_en_n),
        .wr_en_n  (wr_en_n),
        .lane_n   (lane_n),
        .mode     (mode),
        .lane_on  (lane_on)
    );

    lane_sram_wrcap #(.IDX_W(STORE_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .idx     (idx),
        .wdata   (wdata),
        .lane_on (lane_on),
        .commit  (commit),
        .c_idx   (c_idx),
        .c_data  (c_data),
        .c_mask  (c_mask)
    );

    lane_sram_array #(.IDX_W(STORE_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .c_idx    (c_idx),
        .c_data   (c_data),
        .c_mask   (c_mask),
        .rd_go    (mode == MD_READ),
        .rd_idx   (idx),
        .rd_mask  (lane_on),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= (mode == MD_DESEL);
    end

    assign hold_mode = hold_q;
endmodule

// File: rtl/lane_sram_emu_chk.sv
module lane_sram_emu_chk #(
    parameter int ADDR_W  = 18,
    parameter int STORE_W = 10,
    parameter int LANES   = 2,
    parameter int LANE_W  = 8,
    localparam int DW     = LANES * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_lo_n,
    input logic              sel_hi,
    input logic              rd_en_n,
    input logic              wr_en_n,
    input logic [LANES-1:0]  lane_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic [LANES-1:0]  rdata_oe,
    input logic              hold_mode
);
    logic          picked;
    logic [DW-1:0] off_bits;

    assign picked = !sel_lo_n && sel_hi && !(&lane_n);

    always_comb begin
        for (int i = 0; i < LANES; i++)
            off_bits[i*LANE_W +: LANE_W] = {LANE_W{!rdata_oe[i]}};
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rdata_oe == '0 && !hold_mode));

    p_desel_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !picked |=> (rdata_oe == '0 && hold_mode));

    p_outoff_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (picked && rd_en_n && wr_en_n) |=> (rdata_oe == '0 && !hold_mode));

    p_read_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        (picked && !rd_en_n && wr_en_n) |=> (rdata_oe == ~$past(lane_n) && !hold_mode));

    p_undriven_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rdata & off_bits) == '0);

    p_write_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (picked && !wr_en_n) |=> (rdata_oe == '0));
endmodule

bind lane_sram_emu lane_sram_emu_chk #(
    .ADDR_W(ADDR_W), .STORE_W(STORE_W), .LANES(LANES), .LANE_W(LANE_W)
) u_chk (.*);

// File: tb/sim_lane_sram_emu.sv
module sim_lane_sram_emu;
    localparam int SW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_lo_n, sel_hi, rd_en_n, wr_en_n;
    logic [1:0]  lane_n;
    logic [17:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  rdata_oe;
    logic        hold_mode;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // reference model state
    logic [15:0] mm [64];
    bit          p_open = 0;
    int          p_idx;
    logic [15:0] p_dat;
    logic [1:0]  p_msk;
    logic [15:0] e_d  = '0;
    logic [1:0]  e_oe = '0;
    logic        e_h  = 1'b0;
    string       m_tag = "R1";
    string       f_tag = "";

    lane_sram_emu #(.STORE_W(SW)) u0 (
        .clk, .rst, .sel_lo_n, .sel_hi, .rd_en_n, .wr_en_n,
        .lane_n, .addr, .wdata, .rdata, .rdata_oe, .hold_mode
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            p_open = 0; e_d = '0; e_oe = '0; e_h = 0; m_tag = "R1";
        end else begin
            bit desel, wr, rd, done;
            desel = sel_lo_n || !sel_hi || (lane_n == 2'b11);
            wr    = !desel && !wr_en_n;
            rd    = !desel && wr_en_n && !rd_en_n;
            done  = 0;
            if (wr) begin
                p_open = 1; p_idx = int'(addr[SW-1:0]); p_dat = wdata; p_msk = ~lane_n;
            end else if (p_open) begin
                if (p_msk[0]) mm[p_idx][7:0]  = p_dat[7:0];
                if (p_msk[1]) mm[p_idx][15:8] = p_dat[15:8];
                p_open = 0; done = 1;
            end
            e_oe = rd ? ~lane_n : 2'b00;
            e_d  = '0;
            if (e_oe[0]) e_d[7:0]  = mm[addr[SW-1:0]][7:0];
            if (e_oe[1]) e_d[15:8] = mm[addr[SW-1:0]][15:8];
            e_h  = desel;
            m_tag = desel ? "R2" : wr ? "R5" : rd ? (done ? "R8" : "R4") : "R3";
        end
    end

    task automatic cyc();
        string t;
        @(negedge clk);
        t = (f_tag != "") ? f_tag : m_tag;
        total++;
        if (rdata !== e_d || rdata_oe !== e_oe || hold_mode !== e_h) begin
            bad++;
            $display("FAIL %s: got d=%h oe=%b h=%b exp d=%h oe=%b h=%b",
                     t, rdata, rdata_oe, hold_mode, e_d, e_oe, e_h);
        end
    endtask

    task automatic drv(input logic s1, input logic s2, input logic rn, input logic wn,
                       input logic [1:0] ln, input logic [17:0] a, input logic [15:0] d);
        sel_lo_n = s1; sel_hi = s2; rd_en_n = rn; wr_en_n = wn;
        lane_n = ln; addr = a; wdata = d;
        cyc();
    endtask

    task automatic idle(); drv(0, 1, 1, 1, 2'b00, '0, '0); endtask
    task automatic rdw(input logic [17:0] a); drv(0, 1, 0, 1, 2'b00, a, '0); endtask

    initial begin
        drv(1, 0, 1, 1, 2'b11, '0, '0);
        f_tag = "R1"; cyc(); cyc(); f_tag = "";
        rst = 1'b0;
        // fill every word
        for (int i = 0; i < 64; i++) begin
            drv(0, 1, 1, 0, 2'b00, 18'(i), 16'(i * 16'h0101 + 16'h3c00));
            idle();
        end
        for (int i = 0; i < 64; i++) rdw(18'(i));
        // R4: single lanes
        drv(0, 1, 0, 1, 2'b10, 18'd3, '0);
        drv(0, 1, 0, 1, 2'b01, 18'd3, '0);
        // R2: each deselect cause
        drv(1, 1, 0, 1, 2'b00, 18'd4, '0);
        drv(0, 0, 0, 1, 2'b00, 18'd4, '0);
        drv(0, 1, 0, 1, 2'b11, 18'd4, '0);
        // R6: mask and data from final write cycle only
        f_tag = "R6";
        drv(0, 1, 1, 0, 2'b00, 18'd5, 16'h1111);
        drv(0, 1, 1, 0, 2'b10, 18'd5, 16'h22aa);
        idle(); rdw(18'd5);
        drv(0, 1, 1, 0, 2'b01, 18'd9, 16'h7788);
        idle(); rdw(18'd9);
        // R7: each end cause commits
        f_tag = "R7";
        drv(0, 1, 1, 0, 2'b00, 18'd10, 16'ha1a1);
        drv(0, 0, 1, 0, 2'b00, 18'd10, 16'hffff); rdw(18'd10);
        drv(0, 1, 1, 0, 2'b00, 18'd11, 16'hb2b2);
        drv(0, 1, 1, 0, 2'b11, 18'd11, 16'hffff); rdw(18'd11);
        drv(0, 1, 1, 0, 2'b00, 18'd12, 16'hc3c3);
        drv(1, 1, 1, 0, 2'b00, 18'd12, 16'hffff); rdw(18'd12);
        // R5: output enable ignored during write
        f_tag = "R5";
        drv(0, 1, 0, 0, 2'b00, 18'd13, 16'h5e5e);
        drv(0, 1, 0, 0, 2'b00, 18'd13, 16'h6f6f);
        f_tag = "R8";
        rdw(18'd13); rdw(18'd13);
        // R9: aliasing above the stored index
        f_tag = "R9";
        drv(0, 1, 1, 0, 2'b00, 18'h30007, 16'h9a9a);
        rdw(18'h00007); rdw(18'h1c047);
        // R1: reset drops an open write
        f_tag = "R1";
        drv(0, 1, 1, 0, 2'b00, 18'd14, 16'h0bad);
        rst = 1'b1; idle(); rst = 1'b0;
        rdw(18'd14);
        f_tag = "";
        // mixed traffic
        for (int k = 0; k < 3000; k++) begin
            drv(($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2, ($urandom % 3) != 0,
                2'($urandom), 18'($urandom), 16'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        bad++;
        $display("watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule